// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block keeps the coherence record of one memory block at its home node. In the common case it holds up to five node pointers, one per node that has a read copy. A read from a node that is not yet recorded takes a free pointer and is granted at once. A sixth distinct reader moves the entry into full-map mode. The pointers are then copied, one per cycle, into a node-wide bit vector held in an external store, and from then on reads are recorded by setting that node's bit.

A write gathers every recorded sharer except the writer into a pending mask. The block loads an acknowledgement counter with the size of that mask and sends one invalidation per cycle. Write permission is granted only once every acknowledgement has come back. After the grant the writer is the sole owner, and the overflow vector is released.

A later request from another node recalls the owner's copy first. Requests that arrive while a transfer or an invalidation round is in progress are refused with a NACK and must be retried.

Top module: `dirlim_entry`

## Requirements
- R1: During and directly after reset, grant_valid, nack_valid, inv_valid and vs_we are all 0, the entry records no sharer and it is in pointer mode with the block unowned.
- R2: In pointer mode with the block unowned, a read from a node that is already recorded, or from a new node while fewer than NPTR pointers are used, gives grant_valid=1 with grant_excl=0 for that node on the cycle after the request edge, and does not write the store.
- R3: A read from an unrecorded node when all NPTR pointers are used writes the store on NPTR+1 consecutive cycles. The store ends holding bit n set for each former pointer node n and for the requester, and nothing else. The read grant follows after those writes.
- R4: A request that arrives while pointers are being copied into the store gives nack_valid=1 with nack_node equal to the requester on the next cycle. It is not otherwise serviced.
- R5: In full-map mode a read sets the requester's bit in the store with a single write and is granted with grant_excl=0.
- R6: A write in pointer mode with the block unowned sends one invalidation per cycle to each recorded sharer other than the writer, in ascending node number, and never to the writer.
- R7: A write in full-map mode sends invalidations, in ascending order, to every node whose bit is set in the store, except the writer. The store is cleared to all zeros, and the entry returns to pointer mode.
- R8: Write permission (grant_valid=1, grant_excl=1) is given only after as many ack_valid pulses as invalidations sent. No grant appears while any acknowledgement is still owed.
- R9: A request that arrives while an invalidation round is waiting for sends or acknowledgements is refused with nack_valid=1 on the next cycle.
- R10: While the block is owned, a read or write from another node sends exactly one invalidation, to the owner. After its acknowledgement the requester is granted, and grant_excl equals 1 for a write and 0 for a read. After a read the requester is the only recorded sharer and the block is unowned.
- R11: While the block is owned, a read or write from the owner itself is granted on the next cycle with grant_excl=1, and no invalidation is sent.
- R12: A write from a node that is the only recorded sharer sends no invalidation and is granted with grant_excl=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_node | input | PW | Requesting node number |
| ack_valid | input | 1 | One invalidation acknowledgement |
| vs_rdata | input | NODES | Current contents of the overflow vector store |
| vs_we | output | 1 | Write the overflow vector store this cycle |
| vs_wdata | output | NODES | Value to write into the store |
| inv_valid | output | 1 | Invalidation issued this cycle |
| inv_node | output | PW | Node to invalidate |
| grant_valid | output | 1 | Request granted |
| grant_node | output | PW | Node being granted |
| grant_excl | output | 1 | 1 for write permission, 0 for a read copy |
| nack_valid | output | 1 | Request refused, retry later |
| nack_node | output | PW | Node whose request was refused |

## Verification
The hardest state to reach from the ports is an invalidation round in full-map mode with one acknowledgement still owed. To get there, the stimulus first fills all five pointers through reads from distinct nodes and forces an overflow. It adds one reader in full-map mode and then issues a write. The acknowledgements are held back so that a refused request and a long quiet window fall inside the round, before the last acknowledgement is released. A second request is injected one cycle after the overflowing read, so that it lands in the middle of the pointer transfer.

// File: rtl/dirlim_pkg.sv
// Shared types for the limited-pointer directory entry.
// Assumes: single-entry controller; meta-state fits two bits.
package dirlim_pkg;
    typedef enum logic [1:0] {
        MS_PTR   = 2'd0,   // sharers held in hardware pointers
        MS_TRANS = 2'd1,   // pointers being copied into the vector store
        MS_TOW   = 2'd2,   // full-map mode, trap-on-write behaviour
        MS_INVAL = 2'd3    // invalidation round in progress
    } meta_e;
endpackage

// File: rtl/dirlim_ptr_bank.sv
// Bank of NPTR sharer pointers, each a node number with a valid bit.
// Supports: add into lowest free slot, clear one slot, reload to a
// single entry in slot 0 (owner / sole sharer), and a presence lookup.
// Assumes: the caller never adds when full; reload has priority.
module dirlim_ptr_bank #(
    parameter int NODES = 64,
    parameter int NPTR  = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               add_en,
    input  logic [$clog2(NODES)-1:0]           add_node,
    input  logic                               clr_en,
    input  logic [((NPTR>1)?$clog2(NPTR):1)-1:0] clr_idx,
    input  logic                               load_en,
    input  logic [$clog2(NODES)-1:0]           load_node,
    input  logic [$clog2(NODES)-1:0]           look_node,
    output logic [NPTR-1:0][$clog2(NODES)-1:0] slot_node,
    output logic [NPTR-1:0]                    slot_vld,
    output logic                               full,
    output logic                               hit
);
    localparam int PW = $clog2(NODES);
    localparam int IW = (NPTR > 1) ? $clog2(NPTR) : 1;

    logic [NPTR-1:0][PW-1:0] node_q;
    logic [NPTR-1:0]         vld_q;
    logic [IW-1:0]           free_idx;
    logic [NPTR-1:0]         match;

    // Per-slot presence compare against the lookup node.
    for (genvar g = 0; g < NPTR; g++) begin : g_match
        assign match[g] = vld_q[g] && (node_q[g] == look_node);
    end

    // Lowest-numbered free slot.
    always_comb begin
        free_idx = '0;
        for (int i = NPTR - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_idx = IW'(i);
        end
    end

    // Slot storage updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            node_q <= '0;
        end else if (load_en) begin
            vld_q     <= NPTR'(1);
            node_q[0] <= load_node;
        end else begin
            if (add_en && !full) begin
                vld_q[free_idx]  <= 1'b1;
                node_q[free_idx] <= add_node;
            end
            if (clr_en) vld_q[clr_idx] <= 1'b0;
        end
    end

    assign slot_node = node_q;
    assign slot_vld  = vld_q;
    assign full      = &vld_q;
    assign hit       = |match;

    // R2: a new pointer is only taken when a slot is free.
    p_add_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |-> !full);
endmodule

// File: rtl/dirlim_ack_ctr.sv
// Outstanding-acknowledgement counter for one invalidation round.
// Loaded with the number of invalidations, decremented per ack.
// Assumes: acks never exceed the loaded count.
module dirlim_ack_ctr #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    // Load on a new round, otherwise count acknowledgements down.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load_en)             cnt_q <= load_val;
        else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R8: no acknowledgement arrives when none is owed.
    p_no_ack_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load_en) |-> !zero);
    // R8: once drained, the count stays drained until reloaded.
    p_zero_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load_en) |=> zero);
endmodule

// File: rtl/dirlim_entry.sv
// Directory entry controller with NPTR hardware sharer pointers and an
// overflow path into a full bit vector kept in an external store.
// Handles reads (record sharer, grant), writes (invalidate others, count
// acks, grant write permission) and owner recall. Busy states NACK.
// Assumes: store read data reflects the last write on the next cycle;
// at most one request per cycle; acks only follow invalidations.
module dirlim_entry #(
    parameter int NODES = 64,
    parameter int NPTR  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [$clog2(NODES)-1:0] req_node,
    input  logic                     ack_valid,
    input  logic [NODES-1:0]         vs_rdata,
    output logic                     vs_we,
    output logic [NODES-1:0]         vs_wdata,
    output logic                     inv_valid,
    output logic [$clog2(NODES)-1:0] inv_node,
    output logic                     grant_valid,
    output logic [$clog2(NODES)-1:0] grant_node,
    output logic                     grant_excl,
    output logic                     nack_valid,
    output logic [$clog2(NODES)-1:0] nack_node
);
    import dirlim_pkg::*;

    localparam int PW = $clog2(NODES);
    localparam int IW = (NPTR > 1) ? $clog2(NPTR) : 1;
    localparam int SW = $clog2(NPTR + 1);
    localparam int CW = $clog2(NODES + 1);

    meta_e              meta_q, meta_n;
    logic               owned_q, owned_n;
    logic [NODES-1:0]   pend_q, pend_n;
    logic [PW-1:0]      cur_q, cur_n;
    logic               curw_q, curw_n;
    logic [SW-1:0]      step_q, step_n;
    logic               gv_n, gx_n, nv_n;
    logic [PW-1:0]      gn_n;

    logic [NPTR-1:0][PW-1:0] slot_node;
    logic [NPTR-1:0]    slot_vld;
    logic               full, hit;
    logic               add_en, clr_en, load_en;
    logic               ack_load, ack_zero;
    logic [CW-1:0]      ack_val;

    logic [NODES-1:0]   req_bit, cur_bit, own_bit, ptr_mask, start_mask;
    logic [PW-1:0]      low_idx;
    logic               start_inv;

    dirlim_ptr_bank #(.NODES(NODES), .NPTR(NPTR)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .add_en(add_en), .add_node(req_node),
        .clr_en(clr_en), .clr_idx(IW'(step_q)),
        .load_en(load_en), .load_node(cur_q),
        .look_node(req_node),
        .slot_node(slot_node), .slot_vld(slot_vld),
        .full(full), .hit(hit)
    );

    dirlim_ack_ctr #(.CW(CW)) u_ack (
        .clk(clk), .rst_n(rst_n),
        .load_en(ack_load), .load_val(ack_val),
        .dec(ack_valid), .zero(ack_zero)
    );

    // One-hot node masks and the sharer mask built from the pointers.
    always_comb begin
        req_bit = '0; req_bit[req_node]     = 1'b1;
        cur_bit = '0; cur_bit[cur_q]        = 1'b1;
        own_bit = '0; own_bit[slot_node[0]] = 1'b1;
        ptr_mask = '0;
        for (int i = 0; i < NPTR; i++) begin
            if (slot_vld[i]) ptr_mask[slot_node[i]] = 1'b1;
        end
    end

    // Lowest pending node: invalidations go out in ascending order.
    always_comb begin
        low_idx = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (pend_q[i]) low_idx = PW'(i);
        end
    end

    // Main decision logic: next meta-state and all side effects.
    always_comb begin
        meta_n = meta_q;   owned_n = owned_q;  pend_n = pend_q;
        cur_n  = cur_q;    curw_n  = curw_q;   step_n = step_q;
        gv_n = 1'b0; gx_n = 1'b0; gn_n = req_node; nv_n = 1'b0;
        add_en = 1'b0; clr_en = 1'b0; load_en = 1'b0;
        vs_we = 1'b0; vs_wdata = '0;
        start_inv = 1'b0; start_mask = '0;
        unique case (meta_q)
            MS_PTR: if (req_valid) begin
                if (owned_q) begin
                    if (req_node == slot_node[0]) begin
                        gv_n = 1'b1; gx_n = 1'b1;
                    end else begin
                        start_inv = 1'b1; start_mask = own_bit;
                    end
                end else if (req_write) begin
                    start_inv = 1'b1; start_mask = ptr_mask & ~req_bit;
                end else if (hit) begin
                    gv_n = 1'b1;
                end else if (!full) begin
                    add_en = 1'b1; gv_n = 1'b1;
                end else begin
                    meta_n = MS_TRANS; step_n = '0; cur_n = req_node;
                end
            end
            MS_TRANS: begin
                nv_n  = req_valid;
                vs_we = 1'b1;
                if (step_q == SW'(NPTR)) begin
                    vs_wdata = vs_rdata | cur_bit;
                    gv_n = 1'b1; gn_n = cur_q;
                    meta_n = MS_TOW;
                end else begin
                    vs_wdata = (step_q == '0) ? '0 : vs_rdata;
                    vs_wdata[slot_node[IW'(step_q)]] = 1'b1;
                    clr_en = 1'b1;
                    step_n = step_q + 1'b1;
                end
            end
            MS_TOW: if (req_valid) begin
                vs_we = 1'b1;
                if (req_write) begin
                    vs_wdata = '0;
                    start_inv = 1'b1; start_mask = vs_rdata & ~req_bit;
                end else begin
                    vs_wdata = vs_rdata | req_bit;
                    gv_n = 1'b1;
                end
            end
            MS_INVAL: begin
                nv_n = req_valid;
                if (|pend_q) begin
                    pend_n[low_idx] = 1'b0;
                end else if (ack_zero) begin
                    gv_n = 1'b1; gn_n = cur_q; gx_n = curw_q;
                    owned_n = curw_q; load_en = 1'b1;
                    meta_n = MS_PTR;
                end
            end
            default: meta_n = MS_PTR;
        endcase
        if (start_inv) begin
            meta_n = MS_INVAL; pend_n = start_mask;
            cur_n = req_node;  curw_n = req_write;
        end
    end

    assign ack_load = start_inv;
    assign ack_val  = CW'($countones(start_mask));

    // State and registered response outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= MS_PTR; owned_q <= 1'b0; pend_q <= '0;
            cur_q <= '0; curw_q <= 1'b0; step_q <= '0;
            grant_valid <= 1'b0; grant_node <= '0; grant_excl <= 1'b0;
            nack_valid <= 1'b0; nack_node <= '0;
        end else begin
            meta_q <= meta_n; owned_q <= owned_n; pend_q <= pend_n;
            cur_q <= cur_n; curw_q <= curw_n; step_q <= step_n;
            grant_valid <= gv_n; grant_node <= gn_n; grant_excl <= gx_n;
            nack_valid <= nv_n; nack_node <= req_node;
        end
    end

    assign inv_valid = (meta_q == MS_INVAL) && (|pend_q);
    assign inv_node  = low_idx;

    // R2: the store is untouched while sharers live in pointers.
    p_store_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (meta_q == MS_PTR) |-> !vs_we);
    // R3: a pointer transfer only ends by entering full-map mode.
    p_trans_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (meta_q == MS_TRANS) |=> (meta_q == MS_TRANS || meta_q == MS_TOW));
    // R4: a request arriving mid-transfer is refused next cycle.
    p_trans_nack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (meta_q == MS_TRANS && req_valid) |=>
            (nack_valid && nack_node == $past(req_node)));
    // R6: the requester of a round is never invalidated.
    p_inv_not_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_node != cur_q));
endmodule

// File: tb/dirlim_entry_test.sv
module dirlim_entry_test;
    localparam int CLK_PERIOD = 10;
    localparam int NODES = 64;
    localparam int NPTR  = 5;
    localparam int PW    = $clog2(NODES);

    typedef struct {
        int    kind;   // 1 inv, 2 nack, 3 grant
        int    node;
        bit    excl;
        string tag;
    } ev_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, ack_valid = 1'b0;
    logic [PW-1:0] req_node = '0;
    logic [NODES-1:0] store_q = '0;
    logic vs_we, inv_valid, grant_valid, grant_excl, nack_valid;
    logic [NODES-1:0] vs_wdata;
    logic [PW-1:0] inv_node, grant_node, nack_node;

    int checks = 0, failures = 0, wr_cnt = 0;
    bit done = 1'b0;
    ev_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dirlim_entry #(.NODES(NODES), .NPTR(NPTR)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_node(req_node),
        .ack_valid(ack_valid), .vs_rdata(store_q),
        .vs_we(vs_we), .vs_wdata(vs_wdata),
        .inv_valid(inv_valid), .inv_node(inv_node),
        .grant_valid(grant_valid), .grant_node(grant_node), .grant_excl(grant_excl),
        .nack_valid(nack_valid), .nack_node(nack_node)
    );

    // Overflow vector store model.
    always @(posedge clk) if (vs_we) store_q <= vs_wdata;

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(int kind, int node, bit excl, string tag);
        ev_t e;
        e.kind = kind; e.node = node; e.excl = excl; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic observe(int kind, int node, bit excl);
        ev_t e;
        checks++;
        if (q.size() == 0) begin
            failures++;
            $display("FAIL unexpected output (R6 R8 R9 ordering) actual kind=%0d node=%0d expected none",
                     kind, node);
        end else begin
            e = q.pop_front();
            if (e.kind != kind || e.node != node || e.excl != excl) begin
                failures++;
                $display("FAIL %s actual kind=%0d node=%0d excl=%0d expected kind=%0d node=%0d excl=%0d",
                         e.tag, kind, node, excl, e.kind, e.node, e.excl);
            end
        end
    endtask

    // Monitor: compare produced events against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (vs_we) wr_cnt++;
            if (inv_valid)   observe(1, int'(inv_node), 1'b0);
            if (nack_valid)  observe(2, int'(nack_node), 1'b0);
            if (grant_valid) observe(3, int'(grant_node), grant_excl);
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic send(bit w, int n);
        req_valid = 1'b1; req_write = w; req_node = PW'(n);
        tick(1);
        req_valid = 1'b0;
    endtask

    task automatic ack1();
        ack_valid = 1'b1;
        tick(1);
        ack_valid = 1'b0;
    endtask

    task automatic drain(string tag);
        int lim = 0;
        while (q.size() != 0 && lim < 60) begin tick(1); lim++; end
        tick(3);
        check(tag, q.size(), 0);
    endtask

    function automatic logic [NODES-1:0] bits6(int a, int b, int c, int d, int e, int f);
        logic [NODES-1:0] m = '0;
        m[a] = 1'b1; m[b] = 1'b1; m[c] = 1'b1; m[d] = 1'b1; m[e] = 1'b1; m[f] = 1'b1;
        return m;
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        @(negedge clk);
        // R1: reset state
        check("R1 grant", grant_valid, 0);
        check("R1 nack",  nack_valid, 0);
        check("R1 inv",   inv_valid, 0);
        check("R1 store write", vs_we, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        tick(1);

        // R2: reads into pointers, including a repeat reader
        wr_cnt = 0;
        push(3, 3, 0, "R2"); send(0, 3);
        push(3, 9, 0, "R2"); send(0, 9);
        push(3, 17, 0, "R2"); send(0, 17);
        push(3, 9, 0, "R2 repeat"); send(0, 9);
        drain("R2 drain");
        check("R2 no store write", wr_cnt, 0);

        // R6 + R8: write in pointer mode, invalidate 3 and 17, not 9
        push(1, 3, 0, "R6"); push(1, 17, 0, "R6");
        send(1, 9);
        tick(4);
        ack1();
        push(3, 9, 1, "R8");
        ack1();
        drain("R6 drain");

        // R11: owner requests granted directly with write permission
        push(3, 9, 1, "R11 write"); send(1, 9);
        push(3, 9, 1, "R11 read");  send(0, 9);
        drain("R11 drain");

        // R10: read by another node recalls the owner
        push(1, 9, 0, "R10 recall");
        send(0, 20);
        tick(3);
        push(3, 20, 0, "R10 grant");
        ack1();
        drain("R10 drain");

        // R12: sole sharer writes with no invalidation
        push(3, 20, 1, "R12"); send(1, 20);
        drain("R12 drain");

        // R10: write-owned block read by node 1
        push(1, 20, 0, "R10 recall2");
        send(0, 1);
        tick(3);
        push(3, 1, 0, "R10 grant2");
        ack1();
        drain("R10 drain2");

        // Fill all pointers: 1,2,4,5,6
        push(3, 2, 0, "R2 fill"); send(0, 2);
        push(3, 4, 0, "R2 fill"); send(0, 4);
        push(3, 5, 0, "R2 fill"); send(0, 5);
        push(3, 6, 0, "R2 fill"); send(0, 6);
        drain("R2 fill drain");

        // R3 + R4: overflow by node 40, node 7 arrives mid-transfer
        wr_cnt = 0;
        push(2, 7, 0, "R4 nack");
        push(3, 40, 0, "R3 grant");
        send(0, 40);
        send(0, 7);
        drain("R3 drain");
        check("R3 transfer writes", wr_cnt, NPTR + 1);
        check("R3 vector", store_q, bits6(1, 2, 4, 5, 6, 40));

        // R5: full-map read by node 50
        wr_cnt = 0;
        push(3, 50, 0, "R5"); send(0, 50);
        drain("R5 drain");
        check("R5 one write", wr_cnt, 1);
        check("R5 vector", store_q, bits6(1, 2, 4, 5, 6, 40) | (64'd1 << 50));

        // R7 + R8 + R9: write by 4 in full-map mode
        push(1, 1, 0, "R7"); push(1, 2, 0, "R7"); push(1, 5, 0, "R7");
        push(1, 6, 0, "R7"); push(1, 40, 0, "R7"); push(1, 50, 0, "R7");
        send(1, 4);
        tick(8);
        check("R7 vector freed", store_q, 0);
        check("R7 invalidations done", q.size(), 0);
        push(2, 30, 0, "R9 nack");
        send(0, 30);
        tick(2);
        repeat (5) ack1();
        tick(6);
        check("R8 no early grant", q.size(), 0);
        push(3, 4, 1, "R8 grant");
        ack1();
        drain("R8 drain");

        // R11: back in pointer mode, owner 4 reads directly
        push(3, 4, 1, "R11 after overflow"); send(0, 4);
        drain("R11 drain2");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule